// File: doc/BRIEF.md
# FSK Character Retiming Shift-Out Unit

This block sits behind a 1200-baud FSK demodulator and removes the need for a UART in the host controller. It watches the demodulator's serial bit, finds each asynchronous character from its start bit, samples the eight data bits at their centres, and then hands those bits to the host one at a time. The host paces the transfer with strobe pulses on an RXCLK input, and is told that a character is ready through an active-low interrupt line.

When the host holds RXCLK high, retiming is off: no interrupt is raised and the RXD output carries the raw demodulator stream. When the host holds RXCLK low, each completed character raises the interrupt and puts its first bit on RXD. The first rising strobe edge clears the interrupt. The falling edges of the first seven strobes step RXD through the remaining bits. The eighth falling edge hands RXD back to the raw stream. Timing comes from a sample tick at sixteen times the bit rate, and RXCLK is synchronised to the system clock before its edges are used.

Top module: `fsk_retimer`

## Requirements
- R1: After reset, irq_no is high and rxd_o follows demod_i.
- R2: While no character is being shifted out, rxd_o equals demod_i in the same cycle, with no register in the path.
- R3: A character starts when the synchronised demodulator bit, sampled on sample_tick_i, goes from 1 to 0. Eight ticks later the bit is sampled again. If it is 1 at that point, the event is discarded as a glitch and no character is produced.
- R4: The eight data bits are sampled every 16 ticks after the start-bit check. They are presented so that the first bit received (bit 0, the LSB) comes out first.
- R5: If the synchronised RXCLK level is low when a character completes, irq_no goes low and rxd_o shows data bit 0.
- R6: If the synchronised RXCLK level is high when a character completes, irq_no stays high and rxd_o keeps carrying demod_i.
- R7: irq_no stays low until the first synchronised rising edge of RXCLK, and is released by that edge.
- R8: The falling edge of each of strobes 1 to 7 moves rxd_o to the next data bit, in the order bit 1 to bit 7. The eighth falling edge returns rxd_o to demod_i.
- R9: A character that completes while a shift-out is in progress is dropped. The bits being shifted out and irq_no are left unchanged.
- R10: A character that completes in the same cycle as the eighth falling edge is accepted. Its bit 0 goes onto rxd_o and irq_no goes low again.
- R11: A continuous alternating 0101... demodulator stream is received as a series of characters of value 0x55.
- R12: RXCLK passes through SYNC_STAGES flip-flops before its edges are detected. rxd_o responds to an RXCLK edge within SYNC_STAGES+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| demod_i | input | 1 | Raw demodulator bit (1 = mark, 0 = space) |
| rxclk_i | input | 1 | Host strobe; held high to disable retiming |
| rxd_o | output | 1 | Retimed data bit, or raw demodulator bit |
| irq_no | output | 1 | Active-low character-ready interrupt |

## Verification
Two events can land on the same clock edge: a new character completing in the receiver, and the eighth synchronised falling edge of RXCLK that ends the previous shift-out. The bench measures two latencies on an earlier character: from frame start to the interrupt, and from an RXCLK change to the resulting RXD change. It then times the final strobe of one character so that the strobe's effect and the completion of the next back-to-back character fall on the same edge. The result is judged correct only if the new character is taken: irq_no must be low again and rxd_o must show the new bit 0, where a design that frees the unit one edge late would drop the character.

// File: rtl/fsk_retime_pkg.sv
package fsk_retime_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/fsk_level_sync.sv
// Multi-stage synchroniser with edge detection on the synchronised copy.
module fsk_level_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= RST_VAL;
        else         stage_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= stage_q[STAGES-1];
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = stage_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/fsk_char_rx.sv
// Finds start bits on the oversampled stream and gathers the data bits, LSB first.
module fsk_char_rx
  import fsk_retime_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 demod_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] data_o
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam int HALF  = OVERSAMPLE / 2;

  logic [SYNC_STAGES-1:0] dsync_q;
  logic                   bit_s;

  rx_state_e              state_q, state_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic                   prev_q, prev_d;
  logic [DATA_BITS-1:0]   shreg_q, shreg_d;
  logic                   done_q, done_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsync_q <= '1;
    end else begin
      dsync_q[0] <= demod_i;
      for (int i = 1; i < SYNC_STAGES; i++) dsync_q[i] <= dsync_q[i-1];
    end
  end

  assign bit_s = dsync_q[SYNC_STAGES-1];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    prev_d  = prev_q;
    shreg_d = shreg_q;
    done_d  = 1'b0;
    if (tick_i) begin
      case (state_q)
        RX_IDLE: begin
          prev_d = bit_s;
          if (prev_q && !bit_s) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_W'(HALF - 1)) begin
            if (!bit_s) begin
              state_d = RX_DATA;
              cnt_d   = '0;
              idx_d   = '0;
            end else begin
              state_d = RX_IDLE;
              prev_d  = bit_s;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_W'(OVERSAMPLE - 1)) begin
            cnt_d   = '0;
            shreg_d = {bit_s, shreg_q[DATA_BITS-1:1]};
            if (idx_q == IDX_W'(DATA_BITS - 1)) begin
              done_d  = 1'b1;
              state_d = RX_IDLE;
              prev_d  = bit_s;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      prev_q  <= 1'b0;
      shreg_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      prev_q  <= prev_d;
      shreg_q <= shreg_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
  assign data_o = shreg_q;

endmodule

// File: rtl/fsk_shift_out.sv
// Holds a captured character and steps it onto RXD under host strobes.
module fsk_shift_out #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 strobe_lvl_i,
  input  logic                 strobe_rise_i,
  input  logic                 strobe_fall_i,
  input  logic                 demod_i,
  output logic                 rxd_o,
  output logic                 irq_o,
  output logic                 busy_o
);

  localparam int IDX_W = $clog2(DATA_BITS);

  logic                 busy_q, busy_d;
  logic                 irq_q, irq_d;
  logic [IDX_W-1:0]     cnt_q, cnt_d;
  logic [DATA_BITS-1:0] sreg_q, sreg_d;
  logic                 last_bit, free, load;

  assign last_bit = (cnt_q == IDX_W'(DATA_BITS - 1));
  assign free     = !busy_q || (strobe_fall_i && last_bit);
  assign load     = done_i && !strobe_lvl_i && free;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sreg_d = sreg_q;
    irq_d  = irq_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      sreg_d = data_i;
    end else if (busy_q && strobe_fall_i) begin
      if (last_bit) begin
        busy_d = 1'b0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        sreg_d = sreg_q >> 1;
      end
    end
    if (load)               irq_d = 1'b1;
    else if (strobe_rise_i) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      sreg_q <= '0;
    end else begin
      busy_q <= busy_d;
      irq_q  <= irq_d;
      cnt_q  <= cnt_d;
      sreg_q <= sreg_d;
    end
  end

  assign rxd_o  = busy_q ? sreg_q[0] : demod_i;
  assign irq_o  = irq_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/fsk_retimer.sv
module fsk_retimer #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_tick_i,
  input  logic demod_i,
  input  logic rxclk_i,
  output logic rxd_o,
  output logic irq_no
);

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 rx_done;
  logic [DATA_BITS-1:0] rx_data;
  logic                 clk_lvl, clk_rise, clk_fall;
  logic                 so_irq, so_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fsk_level_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_strobe_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .async_i(rxclk_i),
    .level_o(clk_lvl),
    .rise_o (clk_rise),
    .fall_o (clk_fall)
  );

  fsk_char_rx #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .tick_i (sample_tick_i),
    .demod_i(demod_i),
    .done_o (rx_done),
    .data_o (rx_data)
  );

  fsk_shift_out #(
    .DATA_BITS(DATA_BITS)
  ) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .done_i       (rx_done),
    .data_i       (rx_data),
    .strobe_lvl_i (clk_lvl),
    .strobe_rise_i(clk_rise),
    .strobe_fall_i(clk_fall),
    .demod_i      (demod_i),
    .rxd_o        (rxd_o),
    .irq_o        (so_irq),
    .busy_o       (so_busy)
  );

  assign irq_no = ~so_irq;

endmodule

// File: rtl/fsk_retimer_chk.sv
module fsk_retimer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irq_no,
  input logic rxd_o,
  input logic rxclk_lvl,
  input logic rxclk_rise,
  input logic rxclk_fall,
  input logic char_done,
  input logic busy
);

  assert_irq_means_loaded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> busy);

  assert_irq_from_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && $past(irq_no)) |-> $past(char_done));

  assert_no_irq_when_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done && rxclk_lvl && irq_no) |=> irq_no);

  assert_irq_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && rxclk_rise) |=> irq_no);

  assert_rxd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !rxclk_fall && !char_done) |=> $stable(rxd_o));

  assert_drop_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && char_done && !rxclk_fall && !rxclk_rise) |=> ($stable(rxd_o) && $stable(irq_no)));

endmodule

bind fsk_retimer fsk_retimer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_no    (irq_no),
  .rxd_o     (rxd_o),
  .rxclk_lvl (clk_lvl),
  .rxclk_rise(clk_rise),
  .rxclk_fall(clk_fall),
  .char_done (rx_done),
  .busy      (so_busy)
);

// File: tb/fsk_retimer_tb_top.sv
module fsk_retimer_tb_top;

  localparam int OS       = 16;
  localparam int SYNC     = 2;
  localparam int BITCLK   = OS * 2;
  localparam int FRAMECLK = 10 * BITCLK;

  logic clk = 1'b0;
  logic tick = 1'b0;
  logic rst_n, demod, rxclk;
  wire  rxd, irq_n;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   d_lat = 0;
  int   f_lat = 3;
  int   last_start = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick <= ~tick;

  fsk_retimer #(.OVERSAMPLE(OS), .DATA_BITS(8), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_tick_i(tick), .demod_i(demod),
    .rxclk_i(rxclk), .rxd_o(rxd), .irq_no(irq_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: pushes the expected byte, then drives start, 8 data bits LSB first, stop.
  task automatic send_frame(input logic [7:0] b, input bit push);
    while (cyc % 2 != 0) @(negedge clk);
    if (push) exp_q.push_back(b);
    last_start = cyc;
    demod = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      demod = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    demod = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  // Monitor/host: waits for the interrupt, strobes out 8 bits, compares with the queue.
  task automatic host_read(input bit coinc, input bit calib, input string tag);
    int t;
    int target;
    int a;
    logic [7:0] got;
    logic [7:0] expv;
    t = 0;
    got = '0;
    while (irq_n !== 1'b0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 2000) begin
      chk(1'b0, "R5", "interrupt never asserted", int'(irq_n), 0);
      return;
    end
    if (calib) d_lat = cyc - last_start;
    target = last_start + FRAMECLK + d_lat - f_lat;
    if (exp_q.size() > 0)
      chk(rxd === exp_q[0][0], "R5", "bit 0 before first strobe", int'(rxd), int'(exp_q[0][0]));
    for (int i = 0; i < 8; i++) begin
      got[i] = rxd;
      rxclk = 1'b1;
      repeat (5) @(negedge clk);
      if (i == 0) chk(irq_n === 1'b1, "R7", "interrupt after first rise", int'(irq_n), 1);
      if (i == 7 && coinc) begin
        while (cyc < target) @(negedge clk);
        rxclk = 1'b0;
        repeat (f_lat) @(negedge clk);
        chk(irq_n === 1'b0, "R10", "interrupt on coincident completion", int'(irq_n), 0);
        if (exp_q.size() > 1)
          chk(rxd === exp_q[1][0], "R10", "new bit 0 on coincident completion",
              int'(rxd), int'(exp_q[1][0]));
        else
          chk(1'b0, "R10", "second character not queued", exp_q.size(), 2);
      end else begin
        rxclk = 1'b0;
        if (calib && i == 0) begin
          a = cyc;
          while (rxd === got[0] && cyc < a + 20) @(negedge clk);
          f_lat = cyc - a;
          chk(f_lat >= 1 && f_lat <= SYNC + 1, "R12", "strobe-to-rxd latency", f_lat, SYNC + 1);
        end
        repeat (5) @(negedge clk);
      end
    end
    if (!coinc) begin
      chk(rxd === demod, "R8", "rxd raw after eighth fall", int'(rxd), int'(demod));
      chk(irq_n === 1'b1, "R8", "interrupt idle after transfer", int'(irq_n), 1);
    end
    if (exp_q.size() == 0) begin
      chk(1'b0, tag, "unexpected character", int'(got), 0);
    end else begin
      expv = exp_q.pop_front();
      chk(got === expv, tag, "R4 R8 character bits", int'(got), int'(expv));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bad_rxd;
    int bad_irq;
    rst_n = 1'b0;
    demod = 1'b1;
    rxclk = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state
    chk(irq_n === 1'b1, "R1", "interrupt after reset", int'(irq_n), 1);
    chk(rxd === demod, "R1", "rxd after reset", int'(rxd), int'(demod));

    // R2 / R6: retiming disabled, raw stream passes, no interrupt
    bad_rxd = 0;
    bad_irq = 0;
    fork
      send_frame(8'hA3, 1'b0);
      begin
        repeat (FRAMECLK + 40) begin
          @(negedge clk);
          #1;
          if (rxd !== demod) bad_rxd++;
          if (irq_n !== 1'b1) bad_irq++;
        end
      end
    join
    chk(bad_rxd == 0, "R2", "rxd differs from demod in pass mode", bad_rxd, 0);
    chk(bad_irq == 0, "R6", "interrupt while RXCLK high", bad_irq, 0);

    // Retiming enabled; calibrate latencies on 0x96 (bit0=0, bit1=1)
    rxclk = 1'b0;
    repeat (10) @(negedge clk);
    fork
      send_frame(8'h96, 1'b1);
      host_read(1'b0, 1'b1, "R5");
    join

    // R4: several patterns back to back
    fork
      begin
        send_frame(8'hA3, 1'b1);
        send_frame(8'h00, 1'b1);
        send_frame(8'hFF, 1'b1);
        send_frame(8'h5C, 1'b1);
      end
      begin
        for (int k = 0; k < 4; k++) host_read(1'b0, 1'b0, "R4");
      end
    join

    // R11: alternating stream
    fork
      begin
        for (int k = 0; k < 3; k++) send_frame(8'h55, 1'b1);
      end
      begin
        for (int k = 0; k < 3; k++) host_read(1'b0, 1'b0, "R11");
      end
    join

    // R3: short low is rejected, then a real character is still received
    demod = 1'b0;
    repeat (6) @(negedge clk);
    demod = 1'b1;
    repeat (FRAMECLK) @(negedge clk);
    chk(irq_n === 1'b1, "R3", "glitch produced a character", int'(irq_n), 1);
    fork
      send_frame(8'h3C, 1'b1);
      host_read(1'b0, 1'b0, "R3");
    join

    // R9 / R7: second character completes while first is pending; host is late
    send_frame(8'h69, 1'b1);
    send_frame(8'hC3, 1'b0);
    repeat (20) @(negedge clk);
    chk(irq_n === 1'b0, "R7", "interrupt held until first rise", int'(irq_n), 0);
    host_read(1'b0, 1'b0, "R9");
    chk(exp_q.size() == 0, "R9", "queue after dropped character", exp_q.size(), 0);

    // R10: eighth falling edge coincides with next completion
    repeat (40) @(negedge clk);
    fork
      begin
        send_frame(8'h4B, 1'b1);
        send_frame(8'hB4, 1'b1);
      end
      begin
        host_read(1'b1, 1'b0, "R10");
        host_read(1'b0, 1'b0, "R10");
      end
    join
    chk(exp_q.size() == 0, "R10", "characters left unread", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule